// File: doc/BRIEF.md
# Loop divider and phase-frequency detector

This block is the digital core of a frequency-synthesis loop. It takes two digitised oscillator inputs, one for the low band and one for the high band. Each input is a one-cycle tick per oscillator period, synchronous to the system clock. A band bit picks which of the two is used. A down-counter loaded with a 14-bit value N divides the chosen tick stream by N+1 and emits a one-cycle feedback pulse at each terminal count.

The feedback pulses are compared with a reference tick stream that has already been selected upstream. A phase-frequency detector built from two edge-set flags drives two pump outputs:

- **Source (`pump_up_o`)** is asserted when the divided oscillator runs ahead of the reference.
- **Sink (`pump_dn_o`)** is asserted when the divided oscillator runs behind the reference.
- **High-impedance state:** when both outputs are low, the pump is off.

A new N is sampled only at terminal count, so a divided period is never cut short.

Top module: `pll_div_pfd`

## Requirements
- R1: While rst_ni is low, fb_pulse_o, pump_up_o and pump_dn_o are all low.
- R2: The divider pulses fb_pulse_o for exactly one cycle, in the cycle after it consumes a selected tick. The first selected tick after reset produces a pulse. After that, one pulse follows every N+1 selected ticks. Cycles without a selected tick never produce a pulse.
- R3: With band_fm_i = 1 the divider counts vco_fm_i ticks. With band_fm_i = 0 it counts vco_am_i ticks. Ticks on the unselected input have no effect on fb_pulse_o.
- R4: A change of n_val_i part-way through a count does not alter the current period. The new value governs the period that starts at the next terminal count.
- R5: N = 0 divides by 1, so every selected tick yields a pulse. N = 16383 divides by 16384.
- R6: A feedback pulse seen while both pump outputs are low raises pump_up_o in the next cycle, unless a reference tick arrives in the same cycle. pump_up_o then stays high until a reference tick arrives.
- R7: A reference tick seen while both pump outputs are low raises pump_dn_o in the next cycle, unless a feedback pulse arrives in the same cycle. pump_dn_o then stays high until a feedback pulse arrives.
- R8: pump_up_o and pump_dn_o are never both high for more than one cycle. After a cycle with both high, both are low. A feedback pulse and a reference tick that arrive together give exactly one such cycle.
- R9: When no feedback pulse or reference tick arrives and the outputs are not both high, the pump outputs hold their value. After reset they rest at both low, which is the high-impedance state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vco_am_i | input | 1 | Low-band oscillator tick, one cycle per period |
| vco_fm_i | input | 1 | High-band oscillator tick, one cycle per period |
| band_fm_i | input | 1 | 1 selects vco_fm_i, 0 selects vco_am_i |
| n_val_i | input | 14 | Divide code N; the ratio is N+1 |
| ref_tick_i | input | 1 | Reference tick, one cycle per reference period |
| fb_pulse_o | output | 1 | Divided feedback pulse |
| pump_up_o | output | 1 | Source request: divided oscillator is ahead |
| pump_dn_o | output | 1 | Sink request: divided oscillator is behind |

## Verification
Two functions can fall in the same cycle: a feedback pulse arriving at the detector, and a reference tick arriving at the detector. The bench provokes this by placing a selected tick one cycle before a reference tick, so that the registered feedback pulse and the reference meet the detector on the same edge. It then expects a single cycle with both pumps high, followed by both low. The bench also sets one pump and delivers the opposite event, and checks that the overlap lasts exactly one cycle before the pump returns to the off state.

// File: rtl/pll_pkg.sv
package pll_pkg;
  parameter int unsigned PLL_NW = 14;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;
endpackage

// File: rtl/pll_band_sel.sv
module pll_band_sel (
  input  logic band_fm_i,
  input  logic vco_am_i,
  input  logic vco_fm_i,
  output logic tick_o
);
  assign tick_o = band_fm_i ? vco_fm_i : vco_am_i;
endmodule

// File: rtl/pll_fb_div.sv
module pll_fb_div #(
  parameter int unsigned NW = pll_pkg::PLL_NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [NW-1:0] n_i,
  output logic          fb_o
);
  logic [NW-1:0] cnt_q;
  logic          term;

  assign term = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fb_o  <= 1'b0;
    end else begin
      fb_o <= tick_i & term;
      if (tick_i) begin
        // reload only at terminal count: a new N never truncates a period
        cnt_q <= term ? n_i : cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fb_i,
  input  logic           ref_i,
  output pll_pkg::pump_t pump_o
);
  pll_pkg::pump_t q, d;
  logic           clr;

  assign clr = q.up & q.dn;

  always_comb begin
    if (clr) begin
      d = '0;
    end else begin
      d.up = q.up | fb_i;
      d.dn = q.dn | ref_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign pump_o = q;
endmodule

// File: rtl/pll_div_pfd.sv
module pll_div_pfd #(
  parameter int unsigned NW = pll_pkg::PLL_NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vco_am_i,
  input  logic          vco_fm_i,
  input  logic          band_fm_i,
  input  logic [NW-1:0] n_val_i,
  input  logic          ref_tick_i,
  output logic          fb_pulse_o,
  output logic          pump_up_o,
  output logic          pump_dn_o
);
  logic           sel_tick;
  pll_pkg::pump_t pump;

  pll_band_sel u_sel (
    .band_fm_i (band_fm_i),
    .vco_am_i  (vco_am_i),
    .vco_fm_i  (vco_fm_i),
    .tick_o    (sel_tick)
  );

  pll_fb_div #(.NW(NW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (sel_tick),
    .n_i    (n_val_i),
    .fb_o   (fb_pulse_o)
  );

  pll_pfd u_pfd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fb_i   (fb_pulse_o),
    .ref_i  (ref_tick_i),
    .pump_o (pump)
  );

  assign pump_up_o = pump.up;
  assign pump_dn_o = pump.dn;
endmodule

// File: rtl/pll_div_pfd_chk.sv
module pll_div_pfd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vco_am_i,
  input logic vco_fm_i,
  input logic band_fm_i,
  input logic ref_tick_i,
  input logic fb_pulse_o,
  input logic pump_up_o,
  input logic pump_dn_o
);
  AST_FB_FROM_SEL_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> $past(band_fm_i ? vco_fm_i : vco_am_i)); // R3

  AST_UP_ON_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o && !ref_tick_i && !pump_up_o && !pump_dn_o |=> pump_up_o && !pump_dn_o); // R6

  AST_DN_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tick_i && !fb_pulse_o && !pump_up_o && !pump_dn_o |=> pump_dn_o && !pump_up_o); // R7

  AST_NO_BOTH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_up_o && pump_dn_o |=> !pump_up_o && !pump_dn_o); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_pulse_o && !ref_tick_i && !(pump_up_o && pump_dn_o)
    |=> $stable(pump_up_o) && $stable(pump_dn_o)); // R9
endmodule

bind pll_div_pfd pll_div_pfd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vco_am_i   (vco_am_i),
  .vco_fm_i   (vco_fm_i),
  .band_fm_i  (band_fm_i),
  .ref_tick_i (ref_tick_i),
  .fb_pulse_o (fb_pulse_o),
  .pump_up_o  (pump_up_o),
  .pump_dn_o  (pump_dn_o)
);

// File: tb/pll_div_pfd_bench.sv
`timescale 1ns/1ps
module pll_div_pfd_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        am = 1'b0, fm = 1'b0, band = 1'b0, rf = 1'b0;
  logic [13:0] n_val = '0;
  logic        fb, up, dn;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pll_div_pfd u_pll_div_pfd (
    .clk_i(clk), .rst_ni(rst_n), .vco_am_i(am), .vco_fm_i(fm),
    .band_fm_i(band), .n_val_i(n_val), .ref_tick_i(rf),
    .fb_pulse_o(fb), .pump_up_o(up), .pump_dn_o(dn)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle from a negedge, sample at the following negedge
  task automatic cyc(input logic sel, input logic other, input logic r);
    if (band) begin fm = sel; am = other; end
    else      begin am = sel; fm = other; end
    rf = r;
    @(posedge clk);
    @(negedge clk);
    am = 1'b0; fm = 1'b0; rf = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    am = 1'b0; fm = 1'b0; rf = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 fb in reset", fb, 0);
    check("R1 up/dn in reset", {up, dn}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2 R3: sweep small N on both bands, noise on the unselected input
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 10; n++) begin
        band = b[0];
        n_val = 14'(n);
        do_reset();
        for (int i = 0; i < (n + 1) * 3; i++) begin
          cyc(1'b1, 1'b1, 1'b0);
          check("R2 R3 pulse on tick", fb, (i % (n + 1) == 0) ? 1 : 0);
          if (i % 2 == 1) begin
            cyc(1'b0, 1'b1, 1'b0);
            check("R3 R2 no pulse without selected tick", fb, 0);
          end
        end
      end
    end

    // R3: only unselected ticks, never a pulse
    band = 1'b1;
    n_val = 14'd0;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b1, 1'b0);
      check("R3 unselected input ignored", fb, 0);
    end

    // R4: N changes mid-count; pulses expected at ticks 0, 4, 11, 18
    band = 1'b0;
    n_val = 14'd3;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      check("R4 deferred reload",
            fb, (i == 0 || i == 4 || i == 11 || i == 18) ? 1 : 0);
      if (i == 2) n_val = 14'd6;
    end

    // R5: largest code divides by 16384
    band = 1'b1;
    n_val = 14'd16383;
    do_reset();
    for (int i = 0; i < 16384 * 2 + 1; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      if (fb != ((i % 16384 == 0) ? 1'b1 : 1'b0))
        check("R5 divide by 16384", fb, (i % 16384 == 0) ? 1 : 0);
    end
    checks++;

    // R6 R8: feedback first, then reference
    n_val = 14'd0;
    do_reset();
    check("R9 idle after reset", {up, dn}, 0);
    cyc(1'b1, 1'b0, 1'b0);
    check("R2 fb with N=0", fb, 1);
    cyc(1'b0, 1'b0, 1'b0);
    check("R6 up after fb", {up, dn}, 2);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    check("R9 R6 up held", {up, dn}, 2);
    cyc(1'b0, 1'b0, 1'b1);
    check("R8 overlap one cycle", {up, dn}, 3);
    cyc(1'b0, 1'b0, 1'b0);
    check("R8 both cleared", {up, dn}, 0);

    // R7 R8: reference first, then feedback
    cyc(1'b0, 1'b0, 1'b1);
    check("R7 dn after ref", {up, dn}, 1);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    check("R9 R7 dn held", {up, dn}, 1);
    cyc(1'b1, 1'b0, 1'b0);
    check("R7 dn until fb", {up, dn}, 1);
    cyc(1'b0, 1'b0, 1'b0);
    check("R8 overlap after fb", {up, dn}, 3);
    cyc(1'b0, 1'b0, 1'b0);
    check("R8 cleared after fb", {up, dn}, 0);

    // R8: fb and ref reach the detector on the same edge
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    check("R8 coincident both", {up, dn}, 3);
    cyc(1'b0, 1'b0, 1'b0);
    check("R8 coincident cleared", {up, dn}, 0);
    cyc(1'b0, 1'b0, 1'b0);
    check("R9 rest in off state", {up, dn}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule